// File: doc/BRIEF.md
# Synchronous DRAM Row Activation Rule Checker

This block watches the command bus of a four-bank synchronous DRAM, one command per clock, and decides for every non-idle command whether the memory may legally receive it. It keeps the open or closed state of each bank. It also keeps a count of clocks elapsed since each bank's last activation, and one count of clocks since the last activation of any bank. From these it enforces three rules together: the activate-to-column delay, the same-bank activate-to-activate cycle time, and the spacing between activations of different banks.

The timing limits are set as integer picosecond parameters, along with the clock period. They are turned into whole clock counts at elaboration with a round-up division. A limit that falls anywhere in the range (n-1, n] clock periods therefore needs n clocks.

The verdict for a command appears one clock later on two outputs, `accept_o` and `error_o`. A rejected command changes nothing inside the checker, so a controller or a monitor can keep running after a violation. Only the command code and the bank address decide legality. The row and column fields of the bus play no part in the rules and have no ports.

Top module: `bank_act_checker`

## Requirements
- R1: A READ (code 2) or WRITE (code 3) to a bank with no open row is flagged on `error_o`.
- R2: A READ or WRITE to an open bank is flagged when it arrives fewer than `RCD_CLK` clocks after that bank's ACTIVE, and is accepted when it arrives exactly `RCD_CLK` clocks later or after that (8 clocks with the default parameters).
- R3: Each limit in clocks is the ceiling of limit_ps / `TCK_PS`. A 16000 ps limit at 2200 ps gives 8 clocks. A 4400 ps limit at 2200 ps gives exactly 2 clocks, with no extra clock added.
- R4: An ACTIVE (code 1) to a bank whose row is still open is flagged.
- R5: An ACTIVE to a closed bank is flagged when it arrives fewer than `RC_CLK` clocks after that bank's previous ACTIVE (12 clocks with defaults), and is accepted at `RC_CLK` clocks.
- R6: An ACTIVE is flagged when it arrives fewer than `RRD_CLK` clocks after the last accepted ACTIVE to any bank (2 clocks with defaults), and is accepted at `RRD_CLK` clocks.
- R7: A PRECHARGE (code 4) is always accepted. It closes the addressed bank. Sent to an already closed bank it has no effect.
- R8: A flagged command raises `error_o` for one clock. It leaves every bank's open state, every per-bank counter and the cross-bank counter unchanged.
- R9: `accept_o` and `error_o` are registered: each shows the verdict one clock after the command and is never high together with the other. NOP (code 0) raises neither. Codes 5 to 7 are flagged. Both outputs are low after reset.
- R10: All elapsed-clock counters saturate instead of wrapping. All of them start saturated after reset, so timing never blocks the first command after reset, and a long idle stretch never blocks one later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one command per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Command code: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE |
| bank_i | input | 2 | Bank addressed by the command |
| accept_o | output | 1 | Previous clock's command was legal |
| error_o | output | 1 | Previous clock's command was illegal |

## Verification
The bench uses the default parameters: a 2200 ps clock, a 16000 ps activate-to-column delay, a 25000 ps cycle time and a 4400 ps cross-bank spacing. These give limits of 8, 12 and 2 clocks. The 8 comes from a fractional quotient and the 2 from an exact one, so both sides of the round-up rule are tested at their exact boundary cycle. The counters are 4 bits wide and saturate at 15. An idle stretch of 100 clocks would expose a counter that wraps, since a wrapped count would land below the 8-clock limit.

// File: rtl/dram_chk_pkg.sv
// Shared command encoding and elaboration-time helpers for the activation
// checker. Assumes command codes are fixed by the bus the checker watches.
package dram_chk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4
    } cmd_e;

    // Integer division rounded toward positive infinity (positive operands).
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers, for sizing counters.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/elapsed_counter.sv
// Counts clocks since the last restart pulse, saturating at all ones.
// Assumes: restart loads 1, because the first clock after the restarting
// command is one clock later; reset leaves the count saturated.
module elapsed_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    // Restart, advance, or hold at saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= SAT;
        else if (restart_i)
            count_q <= CNT_W'(1);
        else if (count_q != SAT)
            count_q <= count_q + CNT_W'(1);
    end

    assign count_o = count_q;
endmodule

// File: rtl/bank_slot.sv
// State of one bank: whether a row is open and how long since its last
// accepted ACTIVE. Assumes act_i and pre_i are already qualified as legal
// and never arrive together.
module bank_slot #(
    parameter int CNT_W   = 4,
    parameter int RCD_CLK = 8,
    parameter int RC_CLK  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic pre_i,
    output logic open_o,
    output logic rcd_ok_o,
    output logic rc_ok_o
);
    localparam logic [CNT_W-1:0] RCD_LIM = CNT_W'(RCD_CLK);
    localparam logic [CNT_W-1:0] RC_LIM  = CNT_W'(RC_CLK);

    logic             open_q;
    logic [CNT_W-1:0] since_act;

    // Open on ACTIVE, close on PRECHARGE, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= 1'b0;
        else if (act_i)
            open_q <= 1'b1;
        else if (pre_i)
            open_q <= 1'b0;
    end

    elapsed_counter #(.CNT_W(CNT_W)) u_since_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (act_i),
        .count_o   (since_act)
    );

    assign open_o   = open_q;
    assign rcd_ok_o = (since_act >= RCD_LIM);
    assign rc_ok_o  = (since_act >= RC_LIM);
endmodule

// File: rtl/cmd_judge.sv
// Combinational legality decision for the command on the bus this clock.
// Assumes NB is a power of two addressed by a BW-bit bank field.
module cmd_judge #(
    parameter int NB = 4,
    parameter int BW = 2
) (
    input  logic [2:0]    cmd_i,
    input  logic [BW-1:0] bank_i,
    input  logic [NB-1:0] open_i,
    input  logic [NB-1:0] rcd_ok_i,
    input  logic [NB-1:0] rc_ok_i,
    input  logic          rrd_ok_i,
    output logic          active_o,
    output logic          legal_o,
    output logic [NB-1:0] act_o,
    output logic [NB-1:0] pre_o
);
    import dram_chk_pkg::*;

    logic [NB-1:0] sel;

    // One-hot select of the addressed bank.
    always_comb begin
        sel = '0;
        sel[bank_i] = 1'b1;
    end

    // Apply the rule set for each command code.
    always_comb begin
        active_o = 1'b1;
        legal_o  = 1'b0;
        case (cmd_i)
            CMD_NOP: active_o = 1'b0;
            CMD_ACT: legal_o  = !open_i[bank_i] && rc_ok_i[bank_i] && rrd_ok_i;
            CMD_RD,
            CMD_WR:  legal_o  = open_i[bank_i] && rcd_ok_i[bank_i];
            CMD_PRE: legal_o  = 1'b1;
            default: legal_o  = 1'b0;
        endcase
    end

    // Per-bank state updates, only for legal commands.
    always_comb begin
        act_o = (cmd_i == CMD_ACT && legal_o) ? sel : '0;
        pre_o = (cmd_i == CMD_PRE && legal_o) ? sel : '0;
    end
endmodule

// File: rtl/bank_act_checker.sv
// Top: four-bank activation timing and open-row checker. Converts picosecond
// limits to clocks at elaboration and reports a registered verdict per
// command. Assumes one command per clock and RC limit >= RRD limit.
module bank_act_checker #(
    parameter int NUM_BANKS = 4,
    parameter int TCK_PS    = 2200,
    parameter int TRCD_PS   = 16000,
    parameter int TRC_PS    = 25000,
    parameter int TRRD_PS   = 4400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cmd_i,
    input  logic [1:0] bank_i,
    output logic       accept_o,
    output logic       error_o
);
    import dram_chk_pkg::*;

    localparam int BANK_W  = $clog2(NUM_BANKS);
    localparam int RCD_CLK = ceil_div(TRCD_PS, TCK_PS);
    localparam int RC_CLK  = ceil_div(TRC_PS, TCK_PS);
    localparam int RRD_CLK = ceil_div(TRRD_PS, TCK_PS);
    localparam int MAX_CLK = imax(imax(RCD_CLK, RC_CLK), RRD_CLK);
    localparam int CNT_W   = $clog2(MAX_CLK + 1);
    localparam logic [CNT_W-1:0] RRD_LIM = CNT_W'(RRD_CLK);

    logic [NUM_BANKS-1:0] bank_open;
    logic [NUM_BANKS-1:0] rcd_ok;
    logic [NUM_BANKS-1:0] rc_ok;
    logic [NUM_BANKS-1:0] act_en;
    logic [NUM_BANKS-1:0] pre_en;
    logic [CNT_W-1:0]     since_any_act;
    logic                 rrd_ok;
    logic                 is_active;
    logic                 is_legal;
    logic                 accept_q;
    logic                 error_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_slot #(
            .CNT_W   (CNT_W),
            .RCD_CLK (RCD_CLK),
            .RC_CLK  (RC_CLK)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (act_en[b]),
            .pre_i    (pre_en[b]),
            .open_o   (bank_open[b]),
            .rcd_ok_o (rcd_ok[b]),
            .rc_ok_o  (rc_ok[b])
        );
    end

    elapsed_counter #(.CNT_W(CNT_W)) u_since_any (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (|act_en),
        .count_o   (since_any_act)
    );

    assign rrd_ok = (since_any_act >= RRD_LIM);

    cmd_judge #(.NB(NUM_BANKS), .BW(BANK_W)) u_judge (
        .cmd_i    (cmd_i),
        .bank_i   (bank_i[BANK_W-1:0]),
        .open_i   (bank_open),
        .rcd_ok_i (rcd_ok),
        .rc_ok_i  (rc_ok),
        .rrd_ok_i (rrd_ok),
        .active_o (is_active),
        .legal_o  (is_legal),
        .act_o    (act_en),
        .pre_o    (pre_en)
    );

    // Register the verdict so each output is a clean one-clock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
            error_q  <= 1'b0;
        end else begin
            accept_q <= is_active && is_legal;
            error_q  <= is_active && !is_legal;
        end
    end

    assign accept_o = accept_q;
    assign error_o  = error_q;
endmodule

// File: rtl/bank_act_checker_sva.sv
// Property checker for bank_act_checker, bound to every instance of it.
// Observes the command bus, the verdict outputs and the bank open vector.
module bank_act_checker_sva #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    cmd,
    input logic [1:0]    bank,
    input logic [NB-1:0] open,
    input logic          accept,
    input logic          error
);
    // R9: verdict outputs never both high.
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && error));

    // R9: an idle bus raises no verdict.
    a_r9_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd0) |=> (!accept && !error));

    // R1: column command to a closed bank is flagged.
    a_r1_closed_column: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == 3'd2 || cmd == 3'd3) && !open[bank]) |=> error);

    // R4: activating an open bank is flagged.
    a_r4_double_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd1 && open[bank]) |=> error);

    // R7: precharge is always accepted and leaves the bank closed.
    a_r7_pre_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd4) |=> (accept && !open[$past(bank)]));

    // R8: a flagged command leaves the open state untouched.
    a_r8_no_state_change: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (open == $past(open)));
endmodule

bind bank_act_checker bank_act_checker_sva #(.NB(NUM_BANKS)) u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd_i),
    .bank   (bank_i),
    .open   (bank_open),
    .accept (accept_o),
    .error  (error_o)
);

// File: tb/bank_act_checker_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario; each issues commands and checks
// the verdict one clock later. Defaults give limits RCD 8, RC 12, RRD 2.
module bank_act_checker_test;
    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_i = NOP;
    logic [1:0] bank_i = 2'd0;
    logic       accept_o;
    logic       error_o;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    bank_act_checker uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd_i),
        .bank_i   (bank_i),
        .accept_o (accept_o),
        .error_o  (error_o)
    );

    // Drive one command for one clock; outputs are then read 1 ns after the edge.
    task automatic issue(input logic [2:0] c, input logic [1:0] b);
        @(negedge clk);
        cmd_i  = c;
        bank_i = b;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(NOP, 2'd0);
    endtask

    task automatic chk(input string req, input logic acc_x, input logic err_x, input string what);
        n_chk++;
        if (accept_o !== acc_x || error_o !== err_x) begin
            n_fail++;
            $display("FAIL %s %s: accept/error=%b/%b expected %b/%b",
                     req, what, accept_o, error_o, acc_x, err_x);
        end
    endtask

    task automatic t_reset;
        chk("R9", 1'b0, 1'b0, "outputs low in reset");
    endtask

    task automatic t_closed_column;
        idle(2);
        issue(RD, 2'd0); chk("R1", 1'b0, 1'b1, "read to closed bank 0");
        issue(WR, 2'd3); chk("R1", 1'b0, 1'b1, "write to closed bank 3");
    endtask

    task automatic t_rcd;
        idle(20);
        issue(ACT, 2'd0); chk("R10", 1'b1, 1'b0, "first activate after reset");
        idle(6);
        issue(RD, 2'd0);  chk("R2", 1'b0, 1'b1, "read 7 clocks after activate");
        issue(RD, 2'd0);  chk("R3", 1'b1, 1'b0, "read 8 clocks after activate");
        issue(WR, 2'd0);  chk("R2", 1'b1, 1'b0, "write 9 clocks after activate");
        issue(ACT, 2'd0); chk("R4", 1'b0, 1'b1, "activate to open bank");
        issue(PRE, 2'd0); chk("R7", 1'b1, 1'b0, "precharge open bank");
    endtask

    task automatic t_rc;
        idle(20);
        issue(ACT, 2'd1); chk("R5", 1'b1, 1'b0, "activate bank 1");
        issue(PRE, 2'd1); chk("R7", 1'b1, 1'b0, "precharge bank 1");
        idle(9);
        issue(ACT, 2'd1); chk("R5", 1'b0, 1'b1, "re-activate at 11 clocks");
        issue(ACT, 2'd1); chk("R5", 1'b1, 1'b0, "re-activate at 12 clocks");
        issue(PRE, 2'd1);
    endtask

    task automatic t_rrd;
        idle(20);
        issue(ACT, 2'd2); chk("R6", 1'b1, 1'b0, "activate bank 2");
        issue(ACT, 2'd3); chk("R6", 1'b0, 1'b1, "bank 3 one clock later");
        issue(ACT, 2'd3); chk("R3", 1'b1, 1'b0, "bank 3 two clocks later (exact ratio)");
        issue(PRE, 2'd2);
        issue(PRE, 2'd3);
    endtask

    task automatic t_illegal_no_effect;
        idle(20);
        issue(ACT, 2'd0); chk("R8", 1'b1, 1'b0, "activate bank 0");
        issue(ACT, 2'd1); chk("R8", 1'b0, 1'b1, "too-early activate bank 1");
        issue(ACT, 2'd2); chk("R8", 1'b1, 1'b0, "spacing counter not restarted by rejected command");
        idle(20);
        issue(RD, 2'd1);  chk("R8", 1'b0, 1'b1, "rejected activate left bank 1 closed");
        issue(PRE, 2'd0);
        issue(PRE, 2'd2);
    endtask

    task automatic t_pre_closed;
        idle(20);
        issue(PRE, 2'd3); chk("R7", 1'b1, 1'b0, "precharge closed bank 3");
        issue(RD, 2'd3);  chk("R7", 1'b0, 1'b1, "bank 3 still closed");
        issue(ACT, 2'd3); chk("R7", 1'b1, 1'b0, "bank 3 activates normally");
        issue(PRE, 2'd3);
    endtask

    task automatic t_codes;
        issue(NOP, 2'd2);  chk("R9", 1'b0, 1'b0, "NOP raises nothing");
        issue(3'd5, 2'd0); chk("R9", 1'b0, 1'b1, "code 5 flagged");
        issue(3'd7, 2'd1); chk("R9", 1'b0, 1'b1, "code 7 flagged");
    endtask

    task automatic t_saturate;
        idle(2);
        issue(ACT, 2'd1); chk("R10", 1'b1, 1'b0, "activate bank 1");
        idle(100);
        issue(RD, 2'd1);  chk("R10", 1'b1, 1'b0, "read after long idle (no wrap)");
        issue(PRE, 2'd1);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_closed_column();
        t_rcd();
        t_rc();
        t_rrd();
        t_illegal_no_effect();
        t_pre_closed();
        t_codes();
        t_saturate();
        summary();
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        summary();
    end
endmodule